// File: doc/BRIEF.md
# FIFO Request and Interrupt Status Unit

This block sits on the register side of a serial memory controller and owns its data FIFO. A processor reaches it through a small word-addressed register port: one register carries the data words, others hold the request threshold, the expected transfer length, the interrupt mask and the transfer direction. The serial engine on the far side moves words in or out of the same FIFO through a simple push/pop port.

From the FIFO level, the threshold and the words moved so far, the block raises a receive request (words waiting to be read) or a transmit request (room for more words). It latches overrun, underrun and end-of-transfer events. All five flags are sticky and are cleared by writing ones to a clear register. A mask register selects which flags drive the single interrupt line.

A read of the status register returns the flags together with the current FIFO level. A flush, issued through the control register, empties the FIFO and restarts the length tracking.

Top module: `fifo_req_irq`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0x1F (everything masked), the threshold register reads 32, and irq is low.
- R2: The status register (address 0) has receive request at bit 0, transmit request at bit 1, end at bit 2, underrun at bit 3 and overrun at bit 4. Bits 22:16 hold the number of words in the FIFO, and all other bits are 0. A flag becomes visible one cycle after the condition that sets it.
- R3: The data register (address 4) is first-in first-out. With the control direction bit (address 6, bit 0) at 0, the engine pushes and a bus read pops the oldest word. With the bit at 1, a bus write pushes and the engine pops the oldest word. A bus read of an empty FIFO returns 0 and changes nothing. A bus data write while the direction bit is 0 is ignored.
- R4: In the receive direction the receive request flag is set whenever the FIFO holds at least one word and at least threshold (address 3) words.
- R5: In the receive direction the receive request flag is also set when the FIFO is not empty and the engine has pushed at least length (address 5) words since the last length write or flush.
- R6: In the transmit direction the transmit request flag is set when free space (depth minus level) is at least the threshold and fewer than length words have been written by the bus since the last length write or flush.
- R7: An engine push in the receive direction while the FIFO is full sets overrun and is dropped, leaving the level unchanged.
- R8: An engine pop in the transmit direction while the FIFO is empty sets underrun.
- R9: A pulse on eng_done sets the end flag.
- R10: Each flag stays set until a write to the clear register (address 1) has a 1 at its bit. Bits written 0 leave flags alone, and 0x1F clears all five. A set condition in the same cycle as a clear leaves the flag set.
- R11: irq is high exactly when some flag is set whose mask bit (address 2) is 0. Writing 0x1F to the mask drives irq low on the next cycle.
- R12: Writing the control register with bit 1 set empties the FIFO (level 0 on the next cycle) and restarts the length tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data address) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| eng_push | input | 1 | Engine pushes a received word |
| eng_wdata | input | 32 | Word pushed by the engine |
| eng_pop | input | 1 | Engine takes a word to transmit |
| eng_rdata | output | 32 | Oldest FIFO word, 0 when empty |
| eng_done | input | 1 | Engine reports end of transfer |
| irq | output | 1 | Masked interrupt |

## Verification
Two corners need preparation before they can be reached. One is the overrun corner: reaching it takes a threshold raised to the full depth, a length far beyond the transfer, and a complete fill before the extra push. The stimulus then fires that push in the same cycle as a clear of the overrun bit, to show that the set wins. The other is the transmit request that must return only when free space climbs back to the threshold. The bench stops a few words short of the threshold, clears the request, and pops single words while it reads the status after each pop.

// File: rtl/frq_pkg.sv
package frq_pkg;
    localparam int FLAG_N  = 5;
    localparam int F_RREQ  = 0;
    localparam int F_TREQ  = 1;
    localparam int F_END   = 2;
    localparam int F_UNDER = 3;
    localparam int F_OVER  = 4;
    localparam int CNT_LSB = 16;
    localparam int CNT_MAX_W = 7;
    localparam int CTRL_DIR   = 0;
    localparam int CTRL_FLUSH = 1;

    typedef enum logic [2:0] {
        A_STATUS = 3'd0,
        A_CLEAR  = 3'd1,
        A_MASK   = 3'd2,
        A_THRESH = 3'd3,
        A_DATA   = 3'd4,
        A_LENGTH = 3'd5,
        A_CTRL   = 3'd6,
        A_NONE   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/frq_store.sv
module frq_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] lvl;
    } st_t;

    st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.lvl == CNT_W'(DEPTH));
    assign empty   = (st_q.lvl == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign level   = st_q.lvl;
    assign rdata   = empty ? '0 : mem_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = step(st_q.wr);
            if (do_pop)  st_d.rd = step(st_q.rd);
            st_d.lvl = st_q.lvl + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata;
    end
endmodule

// File: rtl/frq_progress.sv
module frq_progress #(
    parameter int DEPTH = 64,
    parameter int LEN_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             dir_tx,
    input  logic [LEN_W-1:0] len,
    input  logic [CNT_W-1:0] thr,
    input  logic [CNT_W-1:0] level,
    input  logic             bus_step,
    input  logic             eng_step,
    output logic             rreq_cond,
    output logic             treq_cond
);
    typedef struct packed {
        logic [LEN_W-1:0] bus_cnt;
        logic [LEN_W-1:0] eng_cnt;
    } prog_t;

    prog_t pr_d, pr_q;
    logic [CNT_W-1:0] free_w;

    assign free_w    = CNT_W'(DEPTH) - level;
    assign rreq_cond = !dir_tx && (level != '0) &&
                       ((level >= thr) || (pr_q.eng_cnt >= len));
    assign treq_cond = dir_tx && (free_w >= thr) && (pr_q.bus_cnt < len);

    always_comb begin
        pr_d = pr_q;
        if (restart) begin
            pr_d = '0;
        end else begin
            if (bus_step && !(&pr_q.bus_cnt)) pr_d.bus_cnt = pr_q.bus_cnt + 1'b1;
            if (eng_step && !(&pr_q.eng_cnt)) pr_d.eng_cnt = pr_q.eng_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end
endmodule

// File: rtl/frq_flags.sv
module frq_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & ~mask_i);
endmodule

// File: rtl/fifo_req_irq.sv
module fifo_req_irq
    import frq_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LEN_W   = 16,
    parameter int THR_RST = 32,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        eng_push,
    input  logic [31:0] eng_wdata,
    input  logic        eng_pop,
    output logic [31:0] eng_rdata,
    input  logic        eng_done,
    output logic        irq
);
    typedef struct packed {
        logic [FLAG_N-1:0] mask;
        logic [CNT_W-1:0]  thr;
        logic [LEN_W-1:0]  len;
        logic              dir;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    reg_addr_e addr_e;
    logic wr_clear, wr_mask, wr_thr, wr_data, wr_len, wr_ctrl, rd_data;
    logic flush, restart, dir_q;
    logic f_push, f_pop, f_full, f_empty;
    logic [31:0] f_wdata, f_rdata;
    logic [CNT_W-1:0] lvl;
    logic bus_step, eng_step, rreq_c, treq_c;
    logic [FLAG_N-1:0] set_v, clr_v, flags;

    assign addr_e   = reg_addr_e'(reg_addr);
    assign wr_clear = reg_wr && (addr_e == A_CLEAR);
    assign wr_mask  = reg_wr && (addr_e == A_MASK);
    assign wr_thr   = reg_wr && (addr_e == A_THRESH);
    assign wr_data  = reg_wr && (addr_e == A_DATA);
    assign wr_len   = reg_wr && (addr_e == A_LENGTH);
    assign wr_ctrl  = reg_wr && (addr_e == A_CTRL);
    assign rd_data  = reg_rd && (addr_e == A_DATA);
    assign dir_q    = cfg_q.dir;
    assign flush    = wr_ctrl && reg_wdata[CTRL_FLUSH];
    assign restart  = flush || wr_len;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_mask) cfg_d.mask = reg_wdata[FLAG_N-1:0];
        if (wr_thr)  cfg_d.thr  = reg_wdata[CNT_W-1:0];
        if (wr_len)  cfg_d.len  = reg_wdata[LEN_W-1:0];
        if (wr_ctrl) cfg_d.dir  = reg_wdata[CTRL_DIR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.mask <= '1;
            cfg_q.thr  <= CNT_W'(THR_RST);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Direction steers which side feeds and which side drains the FIFO.
    assign f_push  = dir_q ? wr_data : eng_push;
    assign f_pop   = dir_q ? eng_pop : rd_data;
    assign f_wdata = dir_q ? reg_wdata : eng_wdata;

    frq_store #(.DEPTH(DEPTH), .WIDTH(32)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(f_push), .wdata(f_wdata), .pop(f_pop), .rdata(f_rdata),
        .level(lvl), .full(f_full), .empty(f_empty)
    );

    assign bus_step = dir_q ? (wr_data && !f_full) : (rd_data && !f_empty);
    assign eng_step = !dir_q && eng_push && !f_full;

    frq_progress #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .restart(restart), .dir_tx(dir_q),
        .len(cfg_q.len), .thr(cfg_q.thr), .level(lvl),
        .bus_step(bus_step), .eng_step(eng_step),
        .rreq_cond(rreq_c), .treq_cond(treq_c)
    );

    always_comb begin
        set_v          = '0;
        set_v[F_RREQ]  = rreq_c;
        set_v[F_TREQ]  = treq_c;
        set_v[F_END]   = eng_done;
        set_v[F_UNDER] = dir_q && eng_pop && f_empty;
        set_v[F_OVER]  = !dir_q && eng_push && f_full;
        clr_v          = wr_clear ? reg_wdata[FLAG_N-1:0] : '0;
    end

    frq_flags #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
        .mask_i(cfg_q.mask), .flags_o(flags), .irq_o(irq)
    );

    assign eng_rdata = f_rdata;

    always_comb begin
        reg_rdata = '0;
        case (addr_e)
            A_STATUS: begin
                reg_rdata[FLAG_N-1:0]      = flags;
                reg_rdata[CNT_LSB +: CNT_W] = lvl;
            end
            A_MASK:   reg_rdata[FLAG_N-1:0] = cfg_q.mask;
            A_THRESH: reg_rdata[CNT_W-1:0]  = cfg_q.thr;
            A_DATA:   reg_rdata = dir_q ? '0 : f_rdata;
            A_LENGTH: reg_rdata[LEN_W-1:0]  = cfg_q.len;
            A_CTRL:   reg_rdata[CTRL_DIR]   = cfg_q.dir;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/frq_checker.sv
module frq_checker
    import frq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [FLAG_N-1:0] wbits,
    input logic              eng_push,
    input logic              eng_pop,
    input logic              eng_done,
    input logic              irq,
    input logic [CNT_W-1:0]  lvl,
    input logic [FLAG_N-1:0] flags,
    input logic              dir
);
    logic clr_wr, mask_wr, ctrl_wr;
    assign clr_wr  = reg_wr && (reg_addr == A_CLEAR);
    assign mask_wr = reg_wr && (reg_addr == A_MASK);
    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= CNT_W'(DEPTH));
    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir && eng_push && lvl == CNT_W'(DEPTH)) |=> flags[F_OVER]);
    a_r8_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && eng_pop && lvl == '0) |=> flags[F_UNDER]);
    a_r9_end_sets: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> flags[F_END]);
    a_r10_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[F_OVER] && !(clr_wr && wbits[F_OVER])) |=> flags[F_OVER]);
    a_r10_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wbits[F_END] && !eng_done) |=> !flags[F_END]);
    a_r11_mask_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && wbits == 5'h1F) |=> !irq);
    a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wbits[CTRL_FLUSH]) |=> (lvl == '0));
endmodule

bind fifo_req_irq frq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wbits(reg_wdata[4:0]), .eng_push(eng_push), .eng_pop(eng_pop),
    .eng_done(eng_done), .irq(irq), .lvl(lvl), .flags(flags), .dir(dir_q)
);

// File: tb/fifo_req_irq_bench.sv
`timescale 1ns/1ps
module fifo_req_irq_bench;
    localparam int DEPTH = 64;
    localparam logic [2:0] AS = 3'd0, AC = 3'd1, AM = 3'd2, AT = 3'd3,
                           AD = 3'd4, AL = 3'd5, AX = 3'd6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0, eng_push = 0, eng_pop = 0, eng_done = 0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, eng_wdata = '0;
    logic [31:0] reg_rdata, eng_rdata;
    logic irq;
    int total = 0, bad = 0;
    bit finished = 0;
    logic [31:0] exp_q [$];

    fifo_req_irq u_fifo_req_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
        .eng_rdata(eng_rdata), .eng_done(eng_done), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 0;
    endtask

    task automatic status(input string tag, input logic [31:0] exp);
        logic [31:0] s;
        @(negedge clk);
        rd(AS, s);
        check(tag, s, exp);
    endtask

    // driver: engine delivers a word, scoreboard expects it back in order
    task automatic eng_in(input logic [31:0] d, input bit keep);
        @(negedge clk); eng_push = 1; eng_wdata = d;
        @(posedge clk); #1 eng_push = 0;
        if (keep) exp_q.push_back(d);
    endtask

    // monitor: bus read compared against the scoreboard
    task automatic bus_out(input string tag);
        logic [31:0] d;
        rd(AD, d);
        if (exp_q.size() > 0) check(tag, d, exp_q.pop_front());
        else check(tag, d, 32'h0);
    endtask

    task automatic bus_in(input logic [31:0] d);
        wr(AD, d);
        exp_q.push_back(d);
    endtask

    task automatic eng_out(input string tag);
        logic [31:0] d;
        @(negedge clk); eng_pop = 1; #1 d = eng_rdata;
        @(posedge clk); #1 eng_pop = 0;
        if (exp_q.size() > 0) check(tag, d, exp_q.pop_front());
        else check(tag, d, 32'h0);
    endtask

    function automatic logic [31:0] st(input int cnt, input logic [4:0] f);
        return (32'(cnt) << 16) | 32'(f);
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        status("R1 status", 32'h0);
        rd(AM, v); check("R1 mask", v, 32'h1F);
        rd(AT, v); check("R1 threshold", v, 32'd32);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // receive: R2 R4 R5 R3
        wr(AT, 4); wr(AL, 6); wr(AC, 32'h1F);
        for (int i = 0; i < 3; i++) eng_in(32'hA000_0000 + i, 1);
        status("R2 level 3 below threshold", st(3, 5'h00));
        eng_in(32'hA000_0003, 1);
        status("R4 rreq at threshold", st(4, 5'h01));
        check("R11 masked irq", {31'b0, irq}, 32'h0);
        wr(AM, 32'h1E); @(negedge clk);
        check("R11 unmasked rreq irq", {31'b0, irq}, 32'h1);
        wr(AM, 32'h01); @(negedge clk);
        check("R11 rreq masked only", {31'b0, irq}, 32'h0);
        wr(AM, 32'h1F);
        for (int i = 0; i < 4; i++) bus_out("R3 rx order");
        status("R10 rreq sticky", st(0, 5'h01));
        wr(AC, 32'h01);
        status("R10 rreq cleared", st(0, 5'h00));
        eng_in(32'hA000_0004, 1); eng_in(32'hA000_0005, 1);
        status("R5 final words rreq", st(2, 5'h01));
        bus_out("R3 rx tail"); bus_out("R3 rx tail");
        wr(AC, 32'h1F);
        bus_out("R3 empty read zero");
        status("R3 empty read no change", st(0, 5'h00));
        wr(AD, 32'hDEAD_BEEF);
        status("R3 rx write ignored", st(0, 5'h00));

        // overrun: R7 R10 R11
        wr(AT, 64); wr(AL, 200);
        for (int i = 0; i < DEPTH; i++) eng_in(32'hB000_0000 + i, 1);
        status("R2 full level", st(64, 5'h01));
        eng_in(32'hBAD0_0000, 0);
        status("R7 overrun set, level held", st(64, 5'h11));
        wr(AM, 32'h0F); @(negedge clk);
        check("R11 overrun irq", {31'b0, irq}, 32'h1);
        repeat (3) @(posedge clk);
        status("R10 overrun sticky", st(64, 5'h11));
        wr(AC, 32'h10);
        status("R10 selective clear", st(64, 5'h01));
        @(negedge clk);
        reg_wr = 1; reg_addr = AC; reg_wdata = 32'h10; eng_push = 1; eng_wdata = 32'hBAD0_0001;
        @(posedge clk); #1 reg_wr = 0; eng_push = 0;
        status("R10 set wins over clear", st(64, 5'h11));
        wr(AC, 32'h10);
        bus_out("R3 after overrun"); bus_out("R3 after overrun");

        // flush R12
        wr(AX, 32'h2);
        exp_q.delete();
        status("R12 flush empties", st(0, 5'h01));
        wr(AC, 32'h1F); wr(AM, 32'h1F);
        status("R10 clear all", st(0, 5'h00));

        // transmit: R6 R3 R8
        wr(AX, 32'h1); wr(AT, 8); wr(AL, 10); wr(AC, 32'h1F);
        status("R6 treq with room", st(0, 5'h02));
        for (int i = 0; i < 10; i++) bus_in(32'hC000_0000 + i);
        wr(AC, 32'h02);
        status("R6 treq off after length", st(10, 5'h00));
        for (int i = 0; i < 10; i++) eng_out("R3 tx order");
        status("R6 drained", st(0, 5'h00));
        eng_out("R8 pop empty zero");
        status("R8 underrun set", st(0, 5'h08));

        wr(AC, 32'h1F); wr(AT, 60); wr(AL, 100);
        for (int i = 0; i < 5; i++) bus_in(32'hD000_0000 + i);
        wr(AC, 32'h1F);
        status("R6 free below threshold", st(5, 5'h00));
        eng_out("R3 tx pop");
        status("R6 free reaches threshold", st(4, 5'h02));
        for (int i = 0; i < 4; i++) eng_out("R3 tx pop");

        // end: R9 R11
        wr(AC, 32'h1F); wr(AM, 32'h1B);
        @(negedge clk); eng_done = 1; @(posedge clk); #1 eng_done = 0;
        rd(AS, v); check("R9 end flag", v & 32'h4, 32'h4);
        check("R9 end irq", {31'b0, irq}, 32'h1);
        wr(AC, 32'h04); @(negedge clk);
        check("R11 treq masked", {31'b0, irq}, 32'h0);
        wr(AM, 32'h00); @(negedge clk);
        check("R11 all enabled", {31'b0, irq}, 32'h1);
        wr(AM, 32'h1F); @(negedge clk);
        check("R11 all masked", {31'b0, irq}, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule